// File: doc/BRIEF.md
# Character Display Buffer Window

This block keeps the eight characters shown on a small text display. It sits on a simple register bus as a window decoded by three address bits. A bus master may read or write 1, 2, 4 or 8 bytes starting at any byte offset in the window. Byte lanes that run past the last slot continue at slot 0, so a multi-byte access is never rejected for misalignment.

Every write that changes the buffer is followed by one refresh. The full 64-bit buffer image goes out on a parallel output, together with a one-cycle valid strobe. The first time the display sink reports that it is ready, before any write has been refreshed, the block sends a single image of eight spaces. This clears the display.

Reads return data one cycle after the request, from a register. The size field carries the access length in bytes. Any value other than 1, 2, 4 or 8 is treated as an unsupported access.

Top module: `disp_buf_window`

## Requirements
- R1: After reset the buffer holds eight 0x20 characters, `disp_valid` is 0 and `bus_rdata` is 0.
- R2: A write of N bytes (`bus_size` = 1, 2, 4 or 8) at offset A = `bus_addr` puts byte k of `bus_wdata` (k = 0 is bits 7:0) into slot (A + k) mod 8. Every other slot is left unchanged.
- R3: A read of N bytes at offset A sets byte k of `bus_rdata` to slot (A + k) mod 8 for k < N, and bytes N and above to zero. The result appears after the clock edge that samples `bus_re` and holds until the next read.
- R4: When a read and a write are sampled at the same edge, the read returns the buffer contents from before that write.
- R5: Every accepted write raises `disp_valid` for exactly the following cycle. During that cycle `disp_data` carries the buffer after the write, with bits 8s+7:8s holding slot s.
- R6: A `bus_size` other than 1, 2, 4 or 8 makes a write change no slot and raise no strobe, and makes a read return zero.
- R7: After reset, the first cycle with `sink_ready` high is handled as follows when no refresh has been sent yet and no write is accepted in that cycle. In the next cycle `disp_valid` is 1 with `disp_data` = 0x2020202020202020. This clear happens at most once per reset. An accepted write before it cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the access in the window |
| bus_size | input | 4 | Access length in bytes |
| bus_wdata | input | 64 | Write data, least significant byte first |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 64 | Registered read data |
| sink_ready | input | 1 | Display sink is ready to accept images |
| disp_data | output | 64 | Full buffer image for the display |
| disp_valid | output | 1 | One-cycle refresh strobe |

## Verification
Writes and reads are tried at three kinds of offsets for every legal size:
- aligned offsets;
- offsets that stay inside the window;
- offsets whose lanes wrap past slot 7.

These patterns separate correct modulo-eight slot mapping from truncation or misaligned indexing. Reading back with sizes other than the one written tells whether upper bytes are zeroed and whether untouched slots keep their contents.

A read issued in the same cycle as a write shows whether the pre-write contents are returned. An illegal size on both a write and a read shows whether such accesses are kept away from the buffer and the strobe. The clear is watched before and after `sink_ready` rises, so that a missing clear, a late clear and a repeated clear can each be told apart.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int DBW_SLOTS  = 8;
  localparam int DBW_CHAR_W = 8;
  localparam int DBW_SIZE_W = 4;
  localparam logic [DBW_CHAR_W-1:0] DBW_BLANK = 8'h20;
endpackage

// File: rtl/dbw_lane_write.sv
module dbw_lane_write #(
  parameter int SLOTS  = 8,
  parameter int CHAR_W = 8,
  parameter int SIZE_W = 4
) (
  input  logic [$clog2(SLOTS)-1:0] offset,
  input  logic [SIZE_W-1:0]        size,
  input  logic [SLOTS*CHAR_W-1:0]  wdata,
  output logic [SLOTS-1:0]         slot_en,
  output logic [SLOTS*CHAR_W-1:0]  slot_data
);
  localparam int IDX_W = $clog2(SLOTS);

  // Each slot works out which data byte lands on it: lane = slot - offset (mod SLOTS)
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [IDX_W-1:0] lane;
    assign lane = IDX_W'(s) - offset;
    assign slot_en[s] = (SIZE_W'(lane) < size);
    assign slot_data[s*CHAR_W +: CHAR_W] = wdata[lane*CHAR_W +: CHAR_W];
  end
endmodule

// File: rtl/dbw_read_gather.sv
module dbw_read_gather #(
  parameter int SLOTS  = 8,
  parameter int CHAR_W = 8,
  parameter int SIZE_W = 4
) (
  input  logic [$clog2(SLOTS)-1:0] offset,
  input  logic [SIZE_W-1:0]        size,
  input  logic [SLOTS*CHAR_W-1:0]  image,
  output logic [SLOTS*CHAR_W-1:0]  rdata
);
  localparam int IDX_W = $clog2(SLOTS);

  // Result byte k comes from slot offset + k (mod SLOTS); lanes at or beyond size read zero
  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    logic [IDX_W-1:0] slot;
    assign slot = offset + IDX_W'(k);
    assign rdata[k*CHAR_W +: CHAR_W] =
      (SIZE_W'(k) < size) ? image[slot*CHAR_W +: CHAR_W] : '0;
  end
endmodule

// File: rtl/dbw_refresh_ctl.sv
module dbw_refresh_ctl #(
  parameter int SLOTS  = 8,
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] BLANK = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_go,
  input  logic                    sink_ready,
  input  logic [SLOTS*CHAR_W-1:0] image_next,
  output logic                    disp_valid,
  output logic [SLOTS*CHAR_W-1:0] disp_data
);
  localparam logic [SLOTS*CHAR_W-1:0] BLANK_IMG = {SLOTS{BLANK}};

  logic                    pend_q, pend_n;
  logic                    valid_n;
  logic [SLOTS*CHAR_W-1:0] data_n;
  logic                    clear_fire;

  always_comb begin
    clear_fire = pend_q & sink_ready & ~wr_go;
    // The clear is retired once any refresh, clear or write, has gone out
    pend_n     = pend_q & ~wr_go & ~clear_fire;
    valid_n    = wr_go | clear_fire;
    data_n     = disp_data;
    if (wr_go)           data_n = image_next;
    else if (clear_fire) data_n = BLANK_IMG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b1;
      disp_valid <= 1'b0;
      disp_data  <= BLANK_IMG;
    end else begin
      pend_q     <= pend_n;
      disp_valid <= valid_n;
      if (valid_n) disp_data <= data_n;
    end
  end
endmodule

// File: rtl/disp_buf_window.sv
module disp_buf_window
  import dbw_pkg::*;
#(
  parameter int SLOTS  = DBW_SLOTS,
  parameter int CHAR_W = DBW_CHAR_W,
  parameter int SIZE_W = DBW_SIZE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SLOTS)-1:0] bus_addr,
  input  logic [SIZE_W-1:0]        bus_size,
  input  logic [SLOTS*CHAR_W-1:0]  bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [SLOTS*CHAR_W-1:0]  bus_rdata,
  input  logic                     sink_ready,
  output logic [SLOTS*CHAR_W-1:0]  disp_data,
  output logic                     disp_valid
);
  localparam int BUF_W = SLOTS * CHAR_W;

  logic [BUF_W-1:0] buf_q, buf_n;
  logic [BUF_W-1:0] rdata_n;
  logic [SLOTS-1:0] slot_en;
  logic [BUF_W-1:0] slot_data;
  logic [BUF_W-1:0] gathered;
  logic             size_ok;
  logic             wr_go;

  // Legal sizes are nonzero powers of two no larger than the buffer
  assign size_ok = (bus_size != '0) &&
                   ((bus_size & (bus_size - 1'b1)) == '0) &&
                   (bus_size <= SIZE_W'(SLOTS));
  assign wr_go   = bus_we & size_ok;

  dbw_lane_write #(.SLOTS(SLOTS), .CHAR_W(CHAR_W), .SIZE_W(SIZE_W)) u_lane_write (
    .offset    (bus_addr),
    .size      (bus_size),
    .wdata     (bus_wdata),
    .slot_en   (slot_en),
    .slot_data (slot_data)
  );

  dbw_read_gather #(.SLOTS(SLOTS), .CHAR_W(CHAR_W), .SIZE_W(SIZE_W)) u_read_gather (
    .offset (bus_addr),
    .size   (bus_size),
    .image  (buf_q),
    .rdata  (gathered)
  );

  always_comb begin
    buf_n = buf_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (wr_go && slot_en[s]) buf_n[s*CHAR_W +: CHAR_W] = slot_data[s*CHAR_W +: CHAR_W];
    end
    rdata_n = size_ok ? gathered : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= {SLOTS{DBW_BLANK}};
      bus_rdata <= '0;
    end else begin
      if (wr_go)  buf_q     <= buf_n;
      if (bus_re) bus_rdata <= rdata_n;
    end
  end

  dbw_refresh_ctl #(.SLOTS(SLOTS), .CHAR_W(CHAR_W), .BLANK(DBW_BLANK)) u_refresh (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (wr_go),
    .sink_ready (sink_ready),
    .image_next (buf_n),
    .disp_valid (disp_valid),
    .disp_data  (disp_data)
  );
endmodule

// File: rtl/dbw_checker.sv
module dbw_checker #(
  parameter int SLOTS  = 8,
  parameter int CHAR_W = 8,
  parameter int SIZE_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [SIZE_W-1:0]       bus_size,
  input logic                    bus_we,
  input logic                    bus_re,
  input logic [SLOTS*CHAR_W-1:0] bus_rdata,
  input logic [SLOTS*CHAR_W-1:0] disp_data,
  input logic                    disp_valid
);
  logic good_size;
  logic wr_ok;
  logic wr_d;
  logic clear_seen;
  logic clear_now;

  assign good_size = (bus_size == SIZE_W'(1)) || (bus_size == SIZE_W'(2)) ||
                     (bus_size == SIZE_W'(4)) || (bus_size == SIZE_W'(8));
  assign wr_ok     = bus_we && good_size;
  assign clear_now = disp_valid && !wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d       <= 1'b0;
      clear_seen <= 1'b0;
    end else begin
      wr_d <= wr_ok;
      if (clear_now) clear_seen <= 1'b1;
    end
  end

  // R5
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> disp_valid);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R6
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !good_size) |=> (bus_rdata == '0));

  // R7
  clear_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |-> (disp_data == {SLOTS{8'h20}}));

  // R7
  clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |-> !clear_seen);
endmodule

bind disp_buf_window dbw_checker #(.SLOTS(SLOTS), .CHAR_W(CHAR_W), .SIZE_W(SIZE_W)) u_dbw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_size   (bus_size),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .disp_data  (disp_data),
  .disp_valid (disp_valid)
);

// File: tb/disp_buf_window_bench.sv
module disp_buf_window_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [3:0]  bus_size;
  logic [63:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [63:0] bus_rdata;
  logic        sink_ready;
  logic [63:0] disp_data;
  logic        disp_valid;

  int   n_chk;
  int   n_err;
  logic done;
  logic [7:0] mdl [8];

  disp_buf_window u_disp_buf_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sink_ready(sink_ready), .disp_data(disp_data), .disp_valid(disp_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int n);
    return (n == 1) || (n == 2) || (n == 4) || (n == 8);
  endfunction

  function automatic logic [63:0] model_image();
    logic [63:0] r;
    for (int s = 0; s < 8; s++) r[s*8 +: 8] = mdl[s];
    return r;
  endfunction

  function automatic logic [63:0] model_read(input int a, input int n);
    logic [63:0] r;
    r = '0;
    if (legal(n)) for (int k = 0; k < n; k++) r[k*8 +: 8] = mdl[(a + k) % 8];
    return r;
  endfunction

  task automatic model_write(input int a, input int n, input logic [63:0] d);
    if (legal(n)) for (int k = 0; k < n; k++) mdl[(a + k) % 8] = d[k*8 +: 8];
  endtask

  // Write, then check the strobe and image in the following cycle (R2, R5, R6)
  task automatic do_write(input int a, input int n, input logic [63:0] d, input string req);
    @(negedge clk);
    bus_addr = 3'(a); bus_size = 4'(n); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, n, d);
    chk({req, " strobe"}, 64'(disp_valid), 64'(legal(n)));
    if (legal(n)) chk({req, " image"}, disp_data, model_image());
    @(negedge clk);
    chk({req, " strobe low"}, 64'(disp_valid), 64'd0);
  endtask

  task automatic do_read(input int a, input int n, input string req);
    @(negedge clk);
    bus_addr = 3'(a); bus_size = 4'(n); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    chk(req, bus_rdata, model_read(a, n));
  endtask

  // R4: read and write sampled together
  task automatic do_read_write();
    logic [63:0] old;
    old = model_read(2, 4);
    @(negedge clk);
    bus_addr = 3'd2; bus_size = 4'd4; bus_wdata = 64'h0000_0000_5A5B_5C5D;
    bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    model_write(2, 4, 64'h0000_0000_5A5B_5C5D);
    chk("R4 old data", bus_rdata, old);
    chk("R4 R5 image", disp_data, model_image());
  endtask

  task automatic test_reset();
    chk("R1 valid", 64'(disp_valid), 64'd0);
    chk("R1 rdata", bus_rdata, 64'd0);
    do_read(0, 8, "R1 blank buffer");
  endtask

  task automatic test_clear();
    repeat (3) begin
      @(negedge clk);
      chk("R7 no clear before ready", 64'(disp_valid), 64'd0);
    end
    sink_ready = 1'b1;
    @(negedge clk);
    chk("R7 clear strobe", 64'(disp_valid), 64'd1);
    chk("R7 clear image", disp_data, 64'h2020_2020_2020_2020);
    repeat (4) begin
      @(negedge clk);
      chk("R7 clear once", 64'(disp_valid), 64'd0);
    end
  endtask

  task automatic test_rdata_hold();
    logic [63:0] held;
    held = bus_rdata;
    repeat (3) @(negedge clk);
    chk("R3 hold", bus_rdata, held);
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_err = 0;
    for (int s = 0; s < 8; s++) mdl[s] = 8'h20;
    rst_n = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    bus_we = 1'b0; bus_re = 1'b0; sink_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_clear();
    do_write(5, 1, 64'h41, "R2 byte");
    do_write(7, 2, 64'h4243, "R2 wrap2");
    do_write(6, 4, 64'h4445_4647, "R2 wrap4");
    do_read(0, 1, "R3 byte");
    do_read(7, 2, "R3 wrap2");
    do_read(6, 4, "R3 wrap4");
    do_read(5, 8, "R3 full wrap");
    do_write(3, 8, 64'h3031_3233_3435_3637, "R2 wrap8");
    do_read(0, 8, "R3 full");
    do_read(1, 4, "R3 inner");
    test_rdata_hold();
    do_write(0, 2, 64'h6162, "R2 aligned");
    do_read(0, 8, "R2 aligned readback");
    do_write(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6 bad write");
    do_read(0, 8, "R6 buffer unchanged");
    do_read(0, 5, "R6 bad read zero");
    do_read_write();
    do_read(0, 8, "R4 readback");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule